// File: doc/BRIEF.md
# Digital Stochastic Spin Update Unit

This block is one probabilistic bit held in ordinary flip-flops. Its one-bit spin encodes +1 as logic 1 and -1 as logic 0. Each update strobe triggers one draw. The unit adds a signed bias to the sum of each neighbour's coupling weight, where a weight counts positive when that neighbour's spin is +1 and negative when it is -1. The resulting local field is scaled by an inverse-temperature factor. A tabulated sigmoid then turns it into a 16-bit probability. That probability is compared against a fresh 16-bit word from a private 32-bit LFSR, and the outcome is registered as the new spin.

Many instances are meant to be tiled into an Ising or Boltzmann sampling fabric. Each spin output feeds the neighbour inputs of other units. An outer scheduler gates the strobes so that coupled units are not updated in the same cycle. A weight LSB stands for 1/32 of a field unit and beta is unsigned Q4.4, so a beta code of 16 means 1.0. Together these make the table argument x equal to 2·beta·field expressed in sixteenths.

Top module: `pbit_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows spin_out = 0 (spin -1) and spin_valid = 0, and the LFSR is loaded with a nonzero seed.
- R2: A cycle with upd_en low leaves spin_out unchanged, and spin_valid is low in the cycle that follows.
- R3: An edge with upd_en high raises spin_valid for exactly the next cycle, together with the new spin. Back-to-back strobes yield one result per cycle.
- R4: The LFSR is never zero. It moves to a new 16-bit draw on every update and holds otherwise, so a zero-field run shows both spin values with frequent changes.
- R5: The field is bias + Σ(±w_i), taking +w_i when nbr_spin[i] = 1 and -w_i when it is 0. Weight i sits in nbr_wt[8i+7:8i], and weights and bias are 8-bit two's complement. With beta nonzero, a positive field never gives a probability below one half and a negative field always gives one below one half.
- R6: The field is saturated to 12 bits signed, and the table argument is limited to ±127. A strongly positive field with large beta gives +1 in at least 99% of updates, and a strongly negative one in at most 1%.
- R7: With x = floor(field·beta/16) limited to ±127, the fraction of +1 results over 4096 updates lies within 0.03 of 1/(1+exp(-x/16)).
- R8: A zero field with nonzero beta gives +1 in one half of updates, within 0.03.
- R9: With beta = 0 the field has no effect and the spin is a fair coin, within 0.03, even under the strongest field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Update strobe, one draw per cycle it is high |
| nbr_spin | input | N_NBR | Neighbour spins, 1 = +1, 0 = -1 |
| nbr_wt | input | N_NBR*WT_W | Packed signed coupling weights, neighbour i at [WT_W*i +: WT_W] |
| bias | input | WT_W | Signed bias added to the field |
| beta | input | BETA_W | Unsigned inverse temperature, Q4.4 |
| spin_out | output | 1 | Current spin, 1 = +1 |
| spin_valid | output | 1 | Pulses for one cycle after each update |

## Verification
The bench sweeps a set of field, spin-pattern and beta settings and measures the fraction of +1 results over 4096 back-to-back updates each. Every fraction is compared with a sigmoid the bench evaluates itself. A design that reversed the sign of a neighbour term, dropped the bias or ignored beta would move those fractions far away from the bench's values, and the opposite-sign pair of settings would then no longer mirror each other. The saturated extremes are checked as well: a design whose table argument wrapped instead of clamping would flip the strong-field cases to near zero. Finally, the zero-field and zero-beta settings catch a probability centre that is off by one table step, and an LFSR that stalls shows up as long runs of one value.

// File: rtl/pbit_pkg.sv
// Package: fixed geometry of the sigmoid table and the spin encoding.
// Assumes a 16-bit probability scale where 65536 would mean certainty.
package pbit_pkg;

    typedef enum logic {SPIN_NEG = 1'b0, SPIN_POS = 1'b1} spin_e;

    localparam int PROB_W  = 16;           // probability and draw width
    localparam int ARG_W   = 8;            // signed table argument width
    localparam int FRAC_W  = 3;            // argument bits inside one segment
    localparam int SEG_W   = ARG_W - 1 - FRAC_W;  // segment index width
    localparam int ARG_MAX = (1 << (ARG_W - 1)) - 1;

    // Knot k holds round(65536 / (1 + exp(-k/2))), i.e. the sigmoid at x = 8k.
    function automatic logic [PROB_W-1:0] sig_knot(input logic [SEG_W:0] k);
        case (k)
            5'd0:    sig_knot = 16'd32768;
            5'd1:    sig_knot = 16'd40794;
            5'd2:    sig_knot = 16'd47911;
            5'd3:    sig_knot = 16'd53581;
            5'd4:    sig_knot = 16'd57724;
            5'd5:    sig_knot = 16'd60565;
            5'd6:    sig_knot = 16'd62428;
            5'd7:    sig_knot = 16'd63615;
            5'd8:    sig_knot = 16'd64357;
            5'd9:    sig_knot = 16'd64816;
            5'd10:   sig_knot = 16'd65097;
            5'd11:   sig_knot = 16'd65269;
            5'd12:   sig_knot = 16'd65374;
            5'd13:   sig_knot = 16'd65438;
            5'd14:   sig_knot = 16'd65476;
            5'd15:   sig_knot = 16'd65500;
            default: sig_knot = 16'd65514;
        endcase
    endfunction

endpackage

// File: rtl/pbit_field.sv
// Local field former: signed sum of +/- weights chosen by neighbour spins,
// plus bias, saturated to ACC_W bits. Purely combinational.
// Assumes weights are packed neighbour 0 in the lowest WT_W bits.
module pbit_field #(
    parameter int N_NBR = 4,
    parameter int WT_W  = 8,
    parameter int ACC_W = 12
) (
    input  logic [N_NBR-1:0]             nbr_spin,
    input  logic [N_NBR*WT_W-1:0]        nbr_wt,
    input  logic signed [WT_W-1:0]       bias,
    output logic signed [ACC_W-1:0]      field
);
    localparam int SUM_W = WT_W + $clog2(N_NBR + 1) + 1;
    localparam int EXT_W = (SUM_W > ACC_W) ? SUM_W : ACC_W + 1;
    localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] SAT_LO = EXT_W'(-(1 <<< (ACC_W - 1)));

    logic signed [EXT_W-1:0] term [N_NBR];
    logic signed [EXT_W-1:0] acc;

    // One signed term per neighbour: +w for spin +1, -w for spin -1.
    for (genvar i = 0; i < N_NBR; i++) begin : g_term
        logic signed [WT_W-1:0] wt_i;
        assign wt_i    = nbr_wt[i*WT_W +: WT_W];
        assign term[i] = nbr_spin[i] ? EXT_W'(wt_i) : -EXT_W'(wt_i);
    end

    // Accumulate all terms on top of the bias.
    always_comb begin
        acc = EXT_W'(bias);
        for (int i = 0; i < N_NBR; i++) begin
            acc = acc + term[i];
        end
    end

    // Clamp the wide sum into the ACC_W field range.
    always_comb begin
        if (acc > SAT_HI)      field = SAT_HI[ACC_W-1:0];
        else if (acc < SAT_LO) field = SAT_LO[ACC_W-1:0];
        else                   field = acc[ACC_W-1:0];
    end

endmodule

// File: rtl/pbit_sigmoid.sv
// Activation: scales the field by beta (Q-format with BETA_FRAC fraction
// bits), clamps to the table argument range, and interpolates linearly
// between sigmoid knots spaced 8 argument steps apart. Negative arguments
// use the mirror identity p(-x) = 1 - p(x). Purely combinational.
module pbit_sigmoid
    import pbit_pkg::*;
#(
    parameter int ACC_W     = 12,
    parameter int BETA_W    = 8,
    parameter int BETA_FRAC = 4
) (
    input  logic signed [ACC_W-1:0] field,
    input  logic [BETA_W-1:0]       beta,
    output logic [PROB_W-1:0]       prob
);
    localparam int PROD_W = ACC_W + BETA_W + 1;
    localparam int STEP_W = PROB_W + FRAC_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [ARG_W-1:0]  arg;
    logic signed [ARG_W-1:0]  neg_arg;
    logic [ARG_W-2:0]         mag;
    logic [SEG_W-1:0]         seg;
    logic [FRAC_W-1:0]        frac;
    logic [PROB_W-1:0]        knot_lo, knot_hi, span, up;
    logic [STEP_W-1:0]        step;

    // Scale by beta and clamp into the signed table argument.
    always_comb begin
        prod   = PROD_W'(field) * PROD_W'($signed({1'b0, beta}));
        scaled = prod >>> BETA_FRAC;
        if (scaled > PROD_W'(ARG_MAX))       arg = ARG_W'(ARG_MAX);
        else if (scaled < PROD_W'(-ARG_MAX)) arg = ARG_W'(-ARG_MAX);
        else                                 arg = scaled[ARG_W-1:0];
    end

    // Split the magnitude into segment index and offset inside the segment.
    always_comb begin
        neg_arg = -arg;
        mag     = arg[ARG_W-1] ? neg_arg[ARG_W-2:0] : arg[ARG_W-2:0];
        seg     = mag[ARG_W-2 -: SEG_W];
        frac    = mag[FRAC_W-1:0];
    end

    // Interpolate the upper half of the curve, then mirror for negatives.
    always_comb begin
        knot_lo = sig_knot({1'b0, seg});
        knot_hi = sig_knot({1'b0, seg} + 5'd1);
        span    = knot_hi - knot_lo;
        step    = STEP_W'(span) * STEP_W'(frac);
        up      = knot_lo + step[STEP_W-1:FRAC_W];
        prob    = arg[ARG_W-1] ? (PROB_W'(0) - up) : up;
    end

endmodule

// File: rtl/pbit_lfsr.sv
// Private random source: Galois LFSR that moves DRAW_W single-bit steps
// each time adv is high, so every update sees an unused word.
// Assumes SEED is nonzero and TAPS describes a maximal-length polynomial.
module pbit_lfsr #(
    parameter int              LFSR_W = 32,
    parameter int              DRAW_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [LFSR_W-1:0] state,
    output logic [DRAW_W-1:0] draw
);
    logic [LFSR_W-1:0] nxt;

    // Unrolled DRAW_W shift-and-fold steps.
    always_comb begin
        nxt = state;
        for (int i = 0; i < DRAW_W; i++) begin
            nxt = {1'b0, nxt[LFSR_W-1:1]} ^ (nxt[0] ? TAPS : '0);
        end
    end

    // Register: seed on reset, step on each update.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= nxt;
    end

    assign draw = state[LFSR_W-1 -: DRAW_W];

endmodule

// File: rtl/pbit_unit.sv
// Top: one stochastic spin. On each upd_en edge the spin becomes +1 when the
// LFSR draw is below the sigmoid probability of the beta-scaled field.
// spin_valid marks the cycle holding a freshly drawn spin.
// Assumes the caller keeps inputs steady around the strobe edge.
module pbit_unit
    import pbit_pkg::*;
#(
    parameter int                N_NBR     = 4,
    parameter int                WT_W      = 8,
    parameter int                ACC_W     = 12,
    parameter int                BETA_W    = 8,
    parameter int                BETA_FRAC = 4,
    parameter int                LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h1ACE_B00C
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_en,
    input  logic [N_NBR-1:0]          nbr_spin,
    input  logic [N_NBR*WT_W-1:0]     nbr_wt,
    input  logic signed [WT_W-1:0]    bias,
    input  logic [BETA_W-1:0]         beta,
    output logic                      spin_out,
    output logic                      spin_valid
);
    logic signed [ACC_W-1:0] field_acc;
    logic [PROB_W-1:0]       act_prob;
    logic [PROB_W-1:0]       draw_word;
    logic [LFSR_W-1:0]       lfsr_state;
    spin_e                   spin_q;
    spin_e                   spin_d;
    logic                    valid_q;

    pbit_field #(.N_NBR(N_NBR), .WT_W(WT_W), .ACC_W(ACC_W)) u_field (
        .nbr_spin (nbr_spin),
        .nbr_wt   (nbr_wt),
        .bias     (bias),
        .field    (field_acc)
    );

    pbit_sigmoid #(.ACC_W(ACC_W), .BETA_W(BETA_W), .BETA_FRAC(BETA_FRAC)) u_sig (
        .field (field_acc),
        .beta  (beta),
        .prob  (act_prob)
    );

    pbit_lfsr #(.LFSR_W(LFSR_W), .DRAW_W(PROB_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (upd_en),
        .state (lfsr_state),
        .draw  (draw_word)
    );

    // Stochastic decision for the next spin.
    always_comb begin
        spin_d = (draw_word < act_prob) ? SPIN_POS : SPIN_NEG;
    end

    // Spin and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spin_q  <= SPIN_NEG;
            valid_q <= 1'b0;
        end else begin
            valid_q <= upd_en;
            if (upd_en) spin_q <= spin_d;
        end
    end

    assign spin_out   = (spin_q == SPIN_POS);
    assign spin_valid = valid_q;

endmodule

// File: rtl/pbit_unit_chk.sv
// Checker for pbit_unit: protocol of strobe and valid, LFSR health, and the
// probability centre and sign relations between field, beta and activation.
module pbit_unit_chk #(
    parameter int ACC_W  = 12,
    parameter int BETA_W = 8,
    parameter int LFSR_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    upd_en,
    input logic [BETA_W-1:0]       beta,
    input logic                    spin_out,
    input logic                    spin_valid,
    input logic [LFSR_W-1:0]       lfsr_state,
    input logic signed [ACC_W-1:0] field_acc,
    input logic [15:0]             act_prob
);
    // R1
    rst_state_chk: assert property (@(posedge clk) !rst_n |=> (!spin_out && !spin_valid));

    // R2
    hold_spin_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd_en |=> $stable(spin_out));

    // R2
    no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd_en |=> !spin_valid);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_en |=> spin_valid);

    // R4
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr_state != '0);

    // R4
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_en |=> lfsr_state != $past(lfsr_state));

    // R4
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !upd_en |=> $stable(lfsr_state));

    // R5
    pos_side_chk: assert property (@(posedge clk) disable iff (!rst_n) (field_acc > 0) |-> act_prob >= 16'h8000);

    // R5
    neg_side_chk: assert property (@(posedge clk) disable iff (!rst_n) (field_acc < 0 && beta != '0) |-> act_prob < 16'h8000);

    // R8
    zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n) (field_acc == 0) |-> act_prob == 16'h8000);

    // R9
    zero_beta_chk: assert property (@(posedge clk) disable iff (!rst_n) (beta == '0) |-> act_prob == 16'h8000);

endmodule

bind pbit_unit pbit_unit_chk #(.ACC_W(ACC_W), .BETA_W(BETA_W), .LFSR_W(LFSR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .beta       (beta),
    .spin_out   (spin_out),
    .spin_valid (spin_valid),
    .lfsr_state (lfsr_state),
    .field_acc  (field_acc),
    .act_prob   (act_prob)
);

// File: tb/sim_pbit_unit.sv
module sim_pbit_unit;
    localparam int N = 4;
    localparam int NS = 4096;
    localparam real TOL = 0.03;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_en = 1'b0;
    logic [N-1:0]      nbr_spin = '0;
    logic [N*8-1:0]    nbr_wt = '0;
    logic signed [7:0] bias = '0;
    logic [7:0]        beta = '0;
    logic              spin_out, spin_valid;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pbit_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .nbr_spin(nbr_spin),
        .nbr_wt(nbr_wt), .bias(bias), .beta(beta),
        .spin_out(spin_out), .spin_valid(spin_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    // Probability of +1 computed from the requirement formulas.
    function automatic real model_p(input logic [N-1:0] s, input logic [N*8-1:0] w,
                                    input int b, input int bt);
        int f;
        int x;
        int wi;
        f = b;
        for (int i = 0; i < N; i++) begin
            wi = $signed(w[i*8 +: 8]);
            f += s[i] ? wi : -wi;
        end
        if (f > 2047) f = 2047;
        if (f < -2048) f = -2048;
        x = (f * bt) >>> 4;
        if (x > 127) x = 127;
        if (x < -127) x = -127;
        return 1.0 / (1.0 + $exp(-x / 16.0));
    endfunction

    // Run NS back-to-back updates; return fraction of +1, valid count, spin changes.
    task automatic run_cfg(input logic [N-1:0] s, input logic [N*8-1:0] w,
                           input int b, input int bt,
                           output real frac, output int nvalid, output int flips);
        int ones;
        logic prev;
        ones = 0; nvalid = 0; flips = 0;
        @(negedge clk);
        nbr_spin = s; nbr_wt = w; bias = 8'(b); beta = 8'(bt); upd_en = 1'b1;
        prev = spin_out;
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            if (spin_valid) nvalid++;
            if (spin_out) ones++;
            if (spin_out != prev) flips++;
            prev = spin_out;
        end
        upd_en = 1'b0;
        frac = real'(ones) / NS;
    endtask

    task automatic law_cfg(input string req, input logic [N-1:0] s, input logic [N*8-1:0] w,
                           input int b, input int bt);
        real fr, p;
        int nv, fl;
        p = model_p(s, w, b, bt);
        run_cfg(s, w, b, bt, fr, nv, fl);
        check((fr - p) <= TOL && (p - fr) <= TOL, req, "fraction of +1", fr, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R3", "watchdog expired", 0.0, 1.0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        real fr, p;
        int nv, fl;
        logic held;
        bit ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(spin_out == 1'b0, "R1", "spin during reset", real'(spin_out), 0.0);
        check(spin_valid == 1'b0, "R1", "valid during reset", real'(spin_valid), 0.0);
        rst_n = 1'b1;
        @(negedge clk);
        check(spin_out == 1'b0 && spin_valid == 1'b0, "R1", "state after reset", real'(spin_out), 0.0);

        // R2: idle keeps spin and valid low
        ok = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (spin_out != 1'b0 || spin_valid) ok = 0;
        end
        check(ok, "R2", "idle after reset", real'(spin_out), 0.0);

        // R3: single strobes give one-cycle valid pulses
        nbr_spin = 4'b1111; nbr_wt = {4{8'sd127}}; bias = 8'sd127; beta = 8'd255;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); upd_en = 1'b1;
            @(negedge clk); upd_en = 1'b0;
            check(spin_valid == 1'b1, "R3", "valid after strobe", real'(spin_valid), 1.0);
            @(negedge clk);
            check(spin_valid == 1'b0, "R3", "valid one cycle only", real'(spin_valid), 0.0);
        end

        // R2: spin holds after strobes while inputs change
        held = spin_out;
        ok = 1;
        nbr_spin = 4'b0000; beta = 8'd200;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (spin_out != held || spin_valid) ok = 0;
        end
        check(ok, "R2", "hold without strobe", real'(spin_out), real'(held));

        // R7 / R3: back-to-back updates, one result per cycle
        p = model_p(4'b1111, {8'sd0, 8'sd5, -8'sd10, 8'sd20}, 0, 16);
        run_cfg(4'b1111, {8'sd0, 8'sd5, -8'sd10, 8'sd20}, 0, 16, fr, nv, fl);
        check(nv == NS, "R3", "valid count in burst", real'(nv), real'(NS));
        check((fr - p) <= TOL && (p - fr) <= TOL, "R7", "moderate positive field", fr, p);

        // R7 / R5: mirrored negative field
        law_cfg("R7", 4'b0000, {8'sd0, 8'sd5, -8'sd10, 8'sd20}, 0, 16);
        law_cfg("R5", 4'b0101, {8'sd40, 8'sd40, 8'sd40, 8'sd40}, 30, 32);
        law_cfg("R5", 4'b0110, {8'sd100, -8'sd7, 8'sd25, -8'sd50}, -20, 24);
        law_cfg("R7", 4'b1001, {8'sd3, -8'sd60, 8'sd12, 8'sd9}, -5, 40);
        law_cfg("R7", 4'b0011, {8'sd8, 8'sd8, -8'sd4, 8'sd6}, 2, 100);

        // R6: saturated extremes
        run_cfg(4'b1111, {4{8'sd127}}, 127, 255, fr, nv, fl);
        check(fr >= 0.99, "R6", "strong positive field", fr, 0.99);
        run_cfg(4'b0000, {4{8'sd127}}, -128, 255, fr, nv, fl);
        check(fr <= 0.01, "R6", "strong negative field", fr, 0.01);

        // R8 / R4: zero field, nonzero beta
        run_cfg(4'b0011, {4{8'sd10}}, 0, 64, fr, nv, fl);
        check((fr - 0.5) <= TOL && (0.5 - fr) <= TOL, "R8", "zero field half", fr, 0.5);
        check(fl > NS / 4, "R4", "spin changes at zero field", real'(fl), real'(NS / 4));

        // R9: beta zero ignores the strongest field
        run_cfg(4'b1111, {4{8'sd127}}, 127, 0, fr, nv, fl);
        check((fr - 0.5) <= TOL && (0.5 - fr) <= TOL, "R9", "beta zero positive field", fr, 0.5);
        run_cfg(4'b0000, {4{8'sd127}}, -128, 0, fr, nv, fl);
        check((fr - 0.5) <= TOL && (0.5 - fr) <= TOL, "R9", "beta zero negative field", fr, 0.5);

        // R2: after a long burst the spin holds again
        @(negedge clk);
        held = spin_out;
        ok = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (spin_out != held || spin_valid) ok = 0;
        end
        check(ok, "R2", "hold after burst", real'(spin_out), real'(held));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule